// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a bank of general-purpose input pins and records transitions in a per-pin edge status register. Software picks the sensitivity of each pin separately. One enable register arms the low-to-high transition and a second one arms the high-to-low transition. A pin with both armed reports either transition. A pin with neither armed never reports.

Status bits stay set until software writes a one to them. A write of zero leaves a bit as it is. The eleven lowest status bits each drive their own interrupt line. All higher bits are merged into one shared interrupt line, which a handler decodes by reading the status register.

Pins are asynchronous to the clock, so each pin passes through a two-stage synchronizer. A transition is found by comparing the synchronized level with its level one clock earlier. The register port is plain and synchronous: a write strobe, an address and write data, with read data returned combinationally from the address.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset both enable registers and the status register read as zero, and every interrupt output is low.
- R2: A pin whose rising enable is set and whose falling enable is clear sets its status bit on a low-to-high transition, and does not set it on a high-to-low transition.
- R3: A pin whose falling enable is set and whose rising enable is clear sets its status bit on a high-to-low transition, and does not set it on a low-to-high transition.
- R4: A pin with both enables set sets its status bit on either transition.
- R5: A pin with neither enable set never sets its status bit.
- R6: Writing the status register clears each bit written as one and leaves each bit written as zero unchanged; writing all ones clears every pending bit.
- R7: Interrupt line `irq_pin[i]` equals status bit i for each i from 0 to 10.
- R8: `irq_group` is high exactly when any status bit from 11 to 27 is set.
- R9: Clearing a pin's enables stops later transitions on that pin from being recorded, and a status bit already set stays set until it is cleared.
- R10: When a transition is captured in the same cycle as a write of one to that status bit, the bit ends up set.
- R11: Register addresses are: 0 for the rising enables, 1 for the falling enables, 2 for the status. All three read back their 28 bits in positions 27:0, and bits 31:28 of the read data are always zero. Address 3 reads as zero.
- R12: A pin change applied between clock edges is visible in the status register and interrupt outputs after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_in | input | 28 | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 28 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_pin | output | 11 | Interrupt lines for pins 0 to 10 |
| irq_group | output | 1 | Combined interrupt line for pins 11 to 27 |

## Verification
A pin change takes effect after three rising edges. Two edges fill the synchronizer, and the third edge loads the status flop. The bench drives pins on falling edges, steps exactly three rising edges, and samples on the following falling edge. For the latency requirement it also samples after only two edges and expects no change.

A register write lands on the single rising edge after the strobe is raised. Read data is combinational, so each read is sampled shortly after the address is set during the low clock phase. The set-versus-clear case times the clear write to land on the same edge that captures a transition already waiting in the synchronizer.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned RD_W   = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_RISE_EN = 2'd0,
    A_FALL_EN = 2'd1,
    A_STATUS  = 2'd2,
    A_NONE    = 2'd3
  } gei_addr_e;
endpackage

// File: rtl/gei_sync.sv
module gei_sync #(
  parameter int unsigned WIDTH  = 28,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level_now,
  output logic [WIDTH-1:0] level_prev
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_prev <= '0;
    else        level_prev <= chain[STAGES-1];

  assign level_now = chain[STAGES-1];
endmodule

// File: rtl/gei_regs.sv
module gei_regs
  import gei_pkg::*;
#(
  parameter int unsigned NUM_PINS = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  input  logic [NUM_PINS-1:0] status_q,
  output logic [NUM_PINS-1:0] rise_en,
  output logic [NUM_PINS-1:0] fall_en,
  output logic [NUM_PINS-1:0] clr_mask,
  output logic [RD_W-1:0]     reg_rdata
);
  logic hit_rise, hit_fall, hit_stat;

  assign hit_rise = reg_we && (reg_addr == A_RISE_EN);
  assign hit_fall = reg_we && (reg_addr == A_FALL_EN);
  assign hit_stat = reg_we && (reg_addr == A_STATUS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
    end else begin
      if (hit_rise) rise_en <= reg_wdata;
      if (hit_fall) fall_en <= reg_wdata;
    end

  assign clr_mask = hit_stat ? reg_wdata : '0;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_RISE_EN: reg_rdata[NUM_PINS-1:0] = rise_en;
      A_FALL_EN: reg_rdata[NUM_PINS-1:0] = fall_en;
      A_STATUS:  reg_rdata[NUM_PINS-1:0] = status_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gei_status.sv
module gei_status #(
  parameter int unsigned NUM_PINS = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_mask,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] status_q
);
  function automatic logic [NUM_PINS-1:0] next_status(
    input logic [NUM_PINS-1:0] cur,
    input logic [NUM_PINS-1:0] set_m,
    input logic [NUM_PINS-1:0] clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, set_mask, clr_mask);

  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr_mask & ~set_mask) |=> ((status_q & $past(clr_mask & ~set_mask)) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |set_mask |=> ((status_q & $past(set_mask)) == $past(set_mask)));

  // R6
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q)) == (status_q & $past(set_mask) & ~$past(status_q))));
endmodule

// File: rtl/gei_irq_fanout.sv
module gei_irq_fanout #(
  parameter int unsigned NUM_PINS   = 28,
  parameter int unsigned NUM_DIRECT = 11
) (
  input  logic [NUM_PINS-1:0]   status_q,
  output logic [NUM_DIRECT-1:0] irq_pin,
  output logic                  irq_group
);
  for (genvar i = 0; i < NUM_DIRECT; i++) begin : g_direct
    assign irq_pin[i] = status_q[i];
  end

  assign irq_group = |status_q[NUM_PINS-1:NUM_DIRECT];
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gei_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 28,
  parameter int unsigned NUM_DIRECT  = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pins_in,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [NUM_PINS-1:0]   reg_wdata,
  output logic [RD_W-1:0]       reg_rdata,
  output logic [NUM_DIRECT-1:0] irq_pin,
  output logic                  irq_group
);
  logic [NUM_PINS-1:0] level_now, level_prev;
  logic [NUM_PINS-1:0] rise_en, fall_en;
  logic [NUM_PINS-1:0] clr_mask, edge_set, status_q;

  function automatic logic [NUM_PINS-1:0] armed_edges(
    input logic [NUM_PINS-1:0] now_l,
    input logic [NUM_PINS-1:0] prev_l,
    input logic [NUM_PINS-1:0] r_en,
    input logic [NUM_PINS-1:0] f_en);
    return (now_l & ~prev_l & r_en) | (~now_l & prev_l & f_en);
  endfunction

  gei_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pins_in),
    .level_now(level_now), .level_prev(level_prev));

  gei_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status_q(status_q), .rise_en(rise_en),
    .fall_en(fall_en), .clr_mask(clr_mask), .reg_rdata(reg_rdata));

  assign edge_set = armed_edges(level_now, level_prev, rise_en, fall_en);

  gei_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk(clk), .rst_n(rst_n), .set_mask(edge_set), .clr_mask(clr_mask),
    .status_q(status_q));

  gei_irq_fanout #(.NUM_PINS(NUM_PINS), .NUM_DIRECT(NUM_DIRECT)) u_irq (
    .status_q(status_q), .irq_pin(irq_pin), .irq_group(irq_group));

  // R5
  disabled_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~($past(rise_en) | $past(fall_en))) == '0));

  // R7
  direct_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin == status_q[NUM_DIRECT-1:0]);

  // R8
  group_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_group == (status_q[NUM_PINS-1:NUM_DIRECT] != '0));

  // R11
  upper_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[RD_W-1:NUM_PINS] == '0);
endmodule

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/100ps
module gpio_edge_irq_tb;
  localparam int N = 28;
  localparam int D = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins_in = '0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [N-1:0]  reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [D-1:0]  irq_pin;
  logic          irq_group;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pin(irq_pin), .irq_group(irq_group));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic chk_state(input string req, input logic [N-1:0] exp);
    logic [31:0] v;
    rd(2'd2, v);
    chk(req, v, {4'h0, exp});
    chk({req, " direct lines"}, {21'd0, irq_pin}, {21'd0, exp[D-1:0]});
    chk({req, " group line"}, {31'd0, irq_group}, {31'd0, |exp[N-1:D]});
  endtask

  task automatic pin_set(input int p, input logic v);
    pins_in[p] = v;
    step(); step(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 rise enable", v, 32'd0);
    rd(2'd1, v); chk("R1 fall enable", v, 32'd0);
    chk_state("R1 status", '0);

    // R11 readback widths and unused address
    wr(2'd0, '1);
    rd(2'd0, v); chk("R11 rise readback", v, 32'h0FFF_FFFF);
    wr(2'd1, 28'h5A5_A5A5);
    rd(2'd1, v); chk("R11 fall readback", v, 32'h05A5_A5A5);
    rd(2'd3, v); chk("R11 address 3", v, 32'd0);
    wr(2'd0, '0); wr(2'd1, '0);

    // R2 R3 R4 R5 R7 R8 sweep over every pin and enable pattern
    for (int p = 0; p < N; p++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        string tag;
        logic [N-1:0] bit_m;
        bit_m = '0; bit_m[p] = 1'b1;
        tag = (cfg == 0) ? "R5" : (cfg == 1) ? "R2" : (cfg == 2) ? "R3" : "R4";
        wr(2'd0, cfg[0] ? bit_m : '0);
        wr(2'd1, cfg[1] ? bit_m : '0);
        pin_set(p, 1'b1);
        chk_state({tag, " rise"}, cfg[0] ? bit_m : '0);
        wr(2'd2, '1);
        pin_set(p, 1'b0);
        chk_state({tag, " fall"}, cfg[1] ? bit_m : '0);
        wr(2'd2, '1);
      end
    end
    wr(2'd0, '0); wr(2'd1, '0);

    // R6 write-one-to-clear
    wr(2'd0, 28'h010_0008);
    pins_in[3] = 1'b1; pins_in[20] = 1'b1;
    step(); step(); step();
    chk_state("R6 both set", 28'h010_0008);
    wr(2'd2, 28'h000_0008);
    chk_state("R6 one cleared", 28'h010_0000);
    wr(2'd2, '0);
    chk_state("R6 zero write", 28'h010_0000);
    wr(2'd2, '1);
    chk_state("R6 all ones", '0);
    pins_in[3] = 1'b0; pins_in[20] = 1'b0;
    step(); step(); step();
    wr(2'd0, '0);

    // R12 latency
    wr(2'd0, 28'h000_0400);
    pins_in[10] = 1'b1;
    step(); step();
    chk_state("R12 two edges", '0);
    step();
    chk_state("R12 three edges", 28'h000_0400);
    wr(2'd2, '1);
    pins_in[10] = 1'b0; step(); step(); step();

    // R9 disable keeps latched state
    wr(2'd0, 28'h000_0020); wr(2'd1, 28'h000_0020);
    pin_set(5, 1'b1);
    chk_state("R9 captured", 28'h000_0020);
    wr(2'd0, '0); wr(2'd1, '0);
    pin_set(5, 1'b0);
    chk_state("R9 latched kept", 28'h000_0020);
    wr(2'd2, '1);
    pin_set(5, 1'b1);
    pin_set(5, 1'b0);
    chk_state("R9 no new capture", '0);

    // R10 set wins over clear in the same cycle
    wr(2'd0, 28'h000_0080); wr(2'd1, 28'h000_0080);
    pin_set(7, 1'b1);
    chk_state("R10 preset", 28'h000_0080);
    pins_in[7] = 1'b0;
    step(); step();
    wr(2'd2, 28'h000_0080);
    chk_state("R10 set wins", 28'h000_0080);
    wr(2'd2, 28'h000_0080);
    chk_state("R10 later clear", '0);

    // R8 group line with several high pins
    wr(2'd0, 28'h800_0800);
    pins_in[27] = 1'b1; pins_in[11] = 1'b1;
    step(); step(); step();
    chk_state("R8 two group bits", 28'h800_0800);
    wr(2'd2, 28'h000_0800);
    chk_state("R8 one group bit", 28'h800_0000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule